// File: doc/BRIEF.md
# Hashed Page Translation Lookup

This block turns a virtual address into a physical address by searching a hash table kept in on-chip RAM. The virtual page number, taken at 1 KiB granularity, is folded by XOR into an 11-bit group index. Each of the 2048 groups holds eight entries, and all eight entries of the chosen group are compared against the page number at once. A hit returns a 29-bit physical address: a 13-bit page number (64 KiB pages in 512 MiB), a 6-bit index naming one 1 KiB section inside that page, and the untouched 10-bit offset. Several virtual pages can therefore share one physical page, each holding its own section. When no entry matches, a fault flag is raised instead.

Software fills the table through a write port that addresses one entry by group and way. The same port removes an entry when it writes the valid bit as 0. Lookups are pipelined, so one can be issued every cycle.

Top module: `ptl_hash_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a fault until an entry is installed.
- R2: A lookup issued with lk_valid high in cycle n produces rs_valid high in cycle n+2 and in no other cycle.
- R3: The searched group is vpn[10:0] XOR vpn[21:11], where vpn = lk_vaddr[31:10]. An entry is found only when it sits in that group and its stored tag equals the full 22-bit vpn.
- R4: On a hit, rs_hit is 1 and rs_fault is 0. rs_paddr is {ppn, section, lk_vaddr[9:0]} (ppn in bits 28:16, section in 15:10), and rs_way gives the matching way.
- R5: On a miss, rs_fault is 1, rs_hit is 0, and rs_paddr and rs_way are both 0. rs_hit and rs_fault are both 0 whenever rs_valid is 0.
- R6: When several ways of the group match, the lowest-numbered way supplies the result.
- R7: A write with wr_valid = 0 invalidates the addressed entry, so later lookups of it miss.
- R8: A lookup in the same cycle as a write to its group sees the contents from before the write. A lookup one cycle later sees the new contents.
- R9: Two virtual pages can map to the same physical page with different section indices, and each returns its own section.
- R10: rs_hit and rs_fault are never high together.
- R11: Lookups issued on consecutive cycles, mixed with writes, each return their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Write one table entry |
| wr_group | input | 11 | Group of the entry written |
| wr_way | input | 3 | Way of the entry written |
| wr_valid | input | 1 | Valid bit written (0 invalidates) |
| wr_vpn | input | 22 | Virtual page tag written |
| wr_ppn | input | 13 | Physical page number written |
| wr_sect | input | 6 | 1 KiB section index written |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation found |
| rs_fault | output | 1 | No translation found |
| rs_way | output | 3 | Way that matched |
| rs_paddr | output | 29 | Translated physical address |

## Verification
The hardest situation to reach is a group holding several live entries at once: two ways with the same tag, a decoy whose tag shares the hash but differs in bits, and the same tag placed in a neighbouring group. Writes aimed at computed groups build exactly that arrangement. The bench then places an invalidating write in the very cycle of a lookup to the same group, to expose read-during-write ordering. A final phase with a small pool of page numbers keeps the hits dense while lookups and writes run back to back.

// File: rtl/ptl_pkg.sv
// Package: default geometry of the hashed page translation lookup.
// Assumes a 32-bit virtual address, 1 KiB offset granularity,
// 13-bit physical page numbers (64 KiB pages in 512 MiB).
package ptl_pkg;
    localparam int PTL_VA_W  = 32;  // virtual address width
    localparam int PTL_OFF_W = 10;  // byte offset inside a 1 KiB section
    localparam int PTL_GRP_W = 11;  // group index width (2048 groups)
    localparam int PTL_WAY_N = 8;   // entries per group
    localparam int PTL_PPN_W = 13;  // physical page number width
    localparam int PTL_SEC_W = 6;   // section index inside a page
endpackage

// File: rtl/ptl_way_bank.sv
// One way of the translation table: a RAM of tag/page/section words
// indexed by group, and a resettable valid bit per group.
// Assumes one read and one write per cycle; the read returns the
// contents from before a write in the same cycle.
module ptl_way_bank #(
    parameter int GRP_W = 11,
    parameter int VPN_W = 22,
    parameter int PPN_W = 13,
    parameter int SEC_W = 6,
    localparam int DEPTH = 1 << GRP_W,
    localparam int WORD_W = VPN_W + PPN_W + SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] rd_grp,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic             wr_vld,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [SEC_W-1:0] wr_sec,
    output logic             q_vld,
    output logic [VPN_W-1:0] q_vpn,
    output logic [PPN_W-1:0] q_ppn,
    output logic [SEC_W-1:0] q_sec
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld_bits;
    logic [WORD_W-1:0] q_word;

    // Payload RAM: registered read, old data on read-during-write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_grp] <= {wr_vpn, wr_ppn, wr_sec};
        end
        q_word <= mem[rd_grp];
    end

    // Valid bits: cleared by reset, read alongside the RAM word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_bits <= '0;
            q_vld    <= 1'b0;
        end else begin
            q_vld <= vld_bits[rd_grp];
            if (wr_en) begin
                vld_bits[wr_grp] <= wr_vld;
            end
        end
    end

    // Split the read word into its fields.
    always_comb begin
        {q_vpn, q_ppn, q_sec} = q_word;
    end
endmodule

// File: rtl/ptl_match_select.sv
// Compares every way of a group against the lookup tag in parallel
// and selects the lowest-numbered matching way.
// Assumes inputs come straight from the way banks' read registers.
module ptl_match_select #(
    parameter int WAY_N = 8,
    parameter int VPN_W = 22,
    parameter int PPN_W = 13,
    parameter int SEC_W = 6,
    localparam int WAY_W = (WAY_N > 1) ? $clog2(WAY_N) : 1
) (
    input  logic [WAY_N-1:0]            way_vld,
    input  logic [WAY_N-1:0][VPN_W-1:0] way_vpn,
    input  logic [WAY_N-1:0][PPN_W-1:0] way_ppn,
    input  logic [WAY_N-1:0][SEC_W-1:0] way_sec,
    input  logic [VPN_W-1:0]            key,
    output logic                        hit,
    output logic [WAY_W-1:0]            way,
    output logic [PPN_W-1:0]            ppn,
    output logic [SEC_W-1:0]            sec
);
    logic [WAY_N-1:0] hv;

    for (genvar i = 0; i < WAY_N; i++) begin : g_cmp
        assign hv[i] = way_vld[i] && (way_vpn[i] == key);
    end

    // Priority pick: a lower way overrides any higher one.
    always_comb begin
        hit = |hv;
        way = '0;
        ppn = '0;
        sec = '0;
        for (int i = WAY_N - 1; i >= 0; i--) begin
            if (hv[i]) begin
                way = WAY_W'(i);
                ppn = way_ppn[i];
                sec = way_sec[i];
            end
        end
    end
endmodule

// File: rtl/ptl_hash_xlate.sv
// Hashed, group-associative page translation lookup.
// Stage 1 folds the page number into a group index and reads all ways;
// stage 2 compares, picks the lowest matching way and registers the
// result. Assumes writes come from software one entry at a time.
module ptl_hash_xlate
    import ptl_pkg::*;
#(
    parameter int VA_W  = PTL_VA_W,
    parameter int OFF_W = PTL_OFF_W,
    parameter int GRP_W = PTL_GRP_W,
    parameter int WAY_N = PTL_WAY_N,
    parameter int PPN_W = PTL_PPN_W,
    parameter int SEC_W = PTL_SEC_W,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int WAY_W = (WAY_N > 1) ? $clog2(WAY_N) : 1,
    localparam int PA_W  = PPN_W + SEC_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_group,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [SEC_W-1:0] wr_sect,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic             rs_fault,
    output logic [WAY_W-1:0] rs_way,
    output logic [PA_W-1:0]  rs_paddr
);
    logic [GRP_W-1:0] lk_grp;
    logic             s1_valid;
    logic [VPN_W-1:0] s1_vpn;
    logic [OFF_W-1:0] s1_off;

    logic [WAY_N-1:0]            bk_vld;
    logic [WAY_N-1:0][VPN_W-1:0] bk_vpn;
    logic [WAY_N-1:0][PPN_W-1:0] bk_ppn;
    logic [WAY_N-1:0][SEC_W-1:0] bk_sec;

    logic             m_hit;
    logic [WAY_W-1:0] m_way;
    logic [PPN_W-1:0] m_ppn;
    logic [SEC_W-1:0] m_sec;

    // XOR fold of the page number into the group index.
    always_comb begin
        lk_grp = '0;
        for (int i = 0; i < VPN_W; i++) begin
            lk_grp[i % GRP_W] = lk_grp[i % GRP_W] ^ lk_vaddr[OFF_W + i];
        end
    end

    // Stage 1: carry the request alongside the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_vpn   <= '0;
            s1_off   <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_vpn   <= lk_vaddr[VA_W-1:OFF_W];
            s1_off   <= lk_vaddr[OFF_W-1:0];
        end
    end

    for (genvar w = 0; w < WAY_N; w++) begin : g_way
        ptl_way_bank #(
            .GRP_W(GRP_W),
            .VPN_W(VPN_W),
            .PPN_W(PPN_W),
            .SEC_W(SEC_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .rd_grp(lk_grp),
            .wr_en (wr_en && (wr_way == WAY_W'(w))),
            .wr_grp(wr_group),
            .wr_vld(wr_valid),
            .wr_vpn(wr_vpn),
            .wr_ppn(wr_ppn),
            .wr_sec(wr_sect),
            .q_vld (bk_vld[w]),
            .q_vpn (bk_vpn[w]),
            .q_ppn (bk_ppn[w]),
            .q_sec (bk_sec[w])
        );
    end

    ptl_match_select #(
        .WAY_N(WAY_N),
        .VPN_W(VPN_W),
        .PPN_W(PPN_W),
        .SEC_W(SEC_W)
    ) u_sel (
        .way_vld(bk_vld),
        .way_vpn(bk_vpn),
        .way_ppn(bk_ppn),
        .way_sec(bk_sec),
        .key    (s1_vpn),
        .hit    (m_hit),
        .way    (m_way),
        .ppn    (m_ppn),
        .sec    (m_sec)
    );

    // Stage 2: register hit or fault and the translated address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_fault <= 1'b0;
            rs_way   <= '0;
            rs_paddr <= '0;
        end else begin
            rs_valid <= s1_valid;
            rs_hit   <= s1_valid && m_hit;
            rs_fault <= s1_valid && !m_hit;
            rs_way   <= (s1_valid && m_hit) ? m_way : '0;
            rs_paddr <= (s1_valid && m_hit) ? {m_ppn, m_sec, s1_off} : '0;
        end
    end
endmodule

// File: rtl/ptl_xlate_chk.sv
// Checker for ptl_hash_xlate: result timing and result flag rules.
// Assumes it is bound to the top and sees only its ports.
module ptl_xlate_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 10,
    parameter int WAY_W = 3,
    parameter int PA_W  = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic             rs_fault,
    input logic [WAY_W-1:0] rs_way,
    input logic [PA_W-1:0]  rs_paddr
);
    logic [1:0] since_rst;

    // Count clock edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R10
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_hit && rs_fault));

    // R2
    two_cycle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (rs_valid == $past(lk_valid, 2)));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> (rs_paddr == '0 && rs_way == '0));

    // R5
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_fault));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && rs_hit) |->
            (rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0], 2)));
endmodule

bind ptl_hash_xlate ptl_xlate_chk #(
    .VA_W (VA_W),
    .OFF_W(OFF_W),
    .WAY_W(WAY_W),
    .PA_W (PA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr),
    .rs_valid(rs_valid),
    .rs_hit  (rs_hit),
    .rs_fault(rs_fault),
    .rs_way  (rs_way),
    .rs_paddr(rs_paddr)
);

// File: tb/sim_ptl_hash_xlate.sv
module sim_ptl_hash_xlate;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_group = '0;
    logic [2:0]  wr_way = '0;
    logic        wr_valid = 1'b0;
    logic [21:0] wr_vpn = '0;
    logic [12:0] wr_ppn = '0;
    logic [5:0]  wr_sect = '0;
    logic        rs_valid, rs_hit, rs_fault;
    logic [2:0]  rs_way;
    logic [28:0] rs_paddr;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    typedef struct {
        bit          v;
        bit          h;
        bit          f;
        logic [2:0]  way;
        logic [28:0] pa;
    } exp_t;

    exp_t expq[$];
    bit          m_vld[int];
    logic [21:0] m_vpn[int];
    logic [12:0] m_ppn[int];
    logic [5:0]  m_sec[int];

    ptl_hash_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .wr_en(wr_en), .wr_group(wr_group), .wr_way(wr_way),
        .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_sect(wr_sect), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_fault(rs_fault), .rs_way(rs_way), .rs_paddr(rs_paddr)
    );

    always #(CLK_P / 2) clk = ~clk;

    // R3: group index from the page number.
    function automatic logic [10:0] hsh(input logic [21:0] v);
        return v[10:0] ^ v[21:11];
    endfunction

    // Reference model: evaluate the lookup, then apply the write.
    always @(posedge clk) begin
        exp_t e;
        e = '{v: 1'b0, h: 1'b0, f: 1'b0, way: 3'd0, pa: 29'd0};
        if (rst_n && lk_valid) begin
            logic [21:0] vpn;
            int g;
            vpn = lk_vaddr[31:10];
            g = int'(hsh(vpn));
            e.v = 1'b1;
            for (int w = 0; w < 8; w++) begin
                int k;
                k = g * 8 + w;
                if (!e.h && m_vld.exists(k) && m_vld[k] && m_vpn[k] == vpn) begin
                    e.h = 1'b1;
                    e.way = 3'(w);
                    e.pa = {m_ppn[k], m_sec[k], lk_vaddr[9:0]};
                end
            end
            e.f = !e.h;
        end
        if (!rst_n) begin
            m_vld.delete();
        end else if (wr_en) begin
            int k;
            k = int'(wr_group) * 8 + int'(wr_way);
            m_vld[k] = wr_valid;
            m_vpn[k] = wr_vpn;
            m_ppn[k] = wr_ppn;
            m_sec[k] = wr_sect;
        end
        expq.push_back(e);
        if (expq.size() > 2) void'(expq.pop_front());
    end

    // Compare the outputs with the model on every clock.
    always @(negedge clk) begin
        if (!rst_n) begin
            if (total < 2) begin
                total++;
                if (rs_valid || rs_hit || rs_fault) begin
                    bad++;
                    $display("FAIL R1 reset state: v/h/f=%b%b%b expected 000",
                             rs_valid, rs_hit, rs_fault);
                end
            end
        end else if (expq.size() == 2 && !done) begin
            exp_t e;
            e = expq[0];
            total++;
            if (rs_valid !== e.v || rs_hit !== e.h || rs_fault !== e.f ||
                rs_way !== e.way || rs_paddr !== e.pa) begin
                bad++;
                $display("FAIL %s: v/h/f=%b%b%b way=%0d pa=%h expected v/h/f=%b%b%b way=%0d pa=%h",
                         cur_req, rs_valid, rs_hit, rs_fault, rs_way, rs_paddr,
                         e.v, e.h, e.f, e.way, e.pa);
            end
        end
    end

    // One cycle of stimulus: optional lookup and optional write.
    task automatic cyc(input bit lk, input logic [31:0] va, input bit we,
                       input logic [10:0] g, input logic [2:0] w, input bit v,
                       input logic [21:0] vpn, input logic [12:0] ppn,
                       input logic [5:0] sec);
        @(negedge clk);
        #1;
        lk_valid = lk;
        lk_vaddr = va;
        wr_en    = we;
        wr_group = g;
        wr_way   = w;
        wr_valid = v;
        wr_vpn   = vpn;
        wr_ppn   = ppn;
        wr_sect  = sec;
    endtask

    task automatic look(input logic [21:0] vpn, input logic [9:0] off);
        cyc(1'b1, {vpn, off}, 1'b0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic put(input logic [10:0] g, input logic [2:0] w, input bit v,
                       input logic [21:0] vpn, input logic [12:0] ppn,
                       input logic [5:0] sec);
        cyc(1'b0, '0, 1'b1, g, w, v, vpn, ppn, sec);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        logic [21:0] va_a, va_b, va_d;
        logic [21:0] pool[6];
        va_a = 22'h12345;
        va_b = va_a ^ 22'h000801;
        va_d = 22'h3C0F1;
        idle(3);
        @(negedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";
        look(va_a, 10'h1A5);
        look(22'h0, 10'h0);
        look(22'h3FFFFF, 10'h3FF);
        idle(2);

        cur_req = "R4";
        put(hsh(va_a), 3'd3, 1'b1, va_a, 13'h1ABC, 6'h2D);
        look(va_a, 10'h1A5);
        look(va_a, 10'h3FF);
        idle(2);

        cur_req = "R3";
        put(hsh(va_a), 3'd0, 1'b1, va_b, 13'h0111, 6'h01);
        put(hsh(va_a) ^ 11'h001, 3'd1, 1'b1, va_a, 13'h0222, 6'h02);
        look(va_b, 10'h010);
        look(va_a, 10'h020);
        look(va_b ^ 22'h000001, 10'h030);
        idle(2);

        cur_req = "R6";
        put(hsh(va_a), 3'd1, 1'b1, va_a, 13'h0F0F, 6'h3F);
        look(va_a, 10'h155);
        idle(2);

        cur_req = "R9";
        put(hsh(va_d), 3'd7, 1'b1, va_d, 13'h1ABC, 6'h05);
        look(va_d, 10'h2AA);
        look(va_a, 10'h2AA);
        idle(2);

        cur_req = "R8";
        cyc(1'b1, {va_a, 10'h077}, 1'b1, hsh(va_a), 3'd1, 1'b0, va_a, '0, '0);
        look(va_a, 10'h078);
        idle(2);

        cur_req = "R7";
        put(hsh(va_a), 3'd3, 1'b0, va_a, '0, '0);
        look(va_a, 10'h001);
        look(va_b, 10'h002);
        idle(2);

        cur_req = "R11";
        for (int i = 0; i < 6; i++) pool[i] = 22'(32'h2A5C3 + i * 32'h10841);
        for (int i = 0; i < 4; i++)
            put(hsh(pool[i]), 3'(i + 2), 1'b1, pool[i], 13'(i * 97), 6'(i * 11));
        for (int i = 0; i < 60; i++) begin
            int p;
            int q;
            p = int'($urandom_range(5, 0));
            q = int'($urandom_range(5, 0));
            cyc(1'b1, {pool[p], 10'($urandom())}, ($urandom_range(3, 0) == 0),
                hsh(pool[q]), 3'($urandom_range(7, 0)), ($urandom_range(1, 0) == 1),
                pool[q], 13'($urandom()), 6'($urandom()));
        end
        idle(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule